// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a 2048-row dynamic RAM alive. A free-running interval timer marks one refresh slot every `INTERVAL` system clocks, which the integrator sets to 32 ms divided by 2048 minus some margin. Each slot adds one owed refresh to a pending count. While anything is owed, the block raises a request toward the access controller and holds it until a grant arrives. It then takes over the DRAM control pins for one refresh cycle. When the cycle completes, the pending count drops by one.

A configuration input selects the style of each refresh, and the block samples it at the moment of grant. In column-strobe-first style, CAS# goes low one cycle before RAS#, so the DRAM walks its own internal row counter and the address bus stays at zero. In row-only style, the block drives an 11-bit row from its own counter and pulses RAS# with CAS# held high. That counter advances after each such refresh. If the grant is late, the owed refreshes are issued back to back once it comes. If the owed count reaches a ceiling, a sticky error flag is raised.

Top module: `refresh_sched`

## Requirements
- R1: After synchronous reset, ref_req, ref_done, drive_en and owe_err are 0, dram_ras_n, dram_cas_n and dram_we_n are 1, and dram_addr is 0.
- R2: One refresh is owed for every `INTERVAL` clocks. With reset released just before edge 1, the first tick happens at edge `INTERVAL`, and ref_req is first seen high after edge `INTERVAL`+2. Over time, the count of completed refreshes equals the count of ticks, so none is lost.
- R3: When cfg_ras_only=0 is sampled at grant, the first driven cycle has CAS# low and RAS# high. The cycles with RAS# low keep CAS# low, and dram_addr stays 0.
- R4: When cfg_ras_only=1 is sampled at grant, CAS# stays high in every driven cycle. The first driven cycle has RAS# high, and dram_addr equals the block's row counter during every RAS#-low cycle.
- R5: A refresh drives exactly 1+`TRAS`+`TRP` cycles with drive_en=1. RAS# is low for exactly `TRAS` consecutive cycles, followed by `TRP` cycles with RAS# and CAS# both high. ref_done is then high for exactly one cycle, with drive_en=0.
- R6: dram_we_n is 1 in every cycle.
- R7: ref_req stays high until ref_gnt is sampled high, and drive_en stays 0 during that time. In the first cycle after the grant, drive_en=1 and ref_req=0. drive_en is never 1 unless ref_gnt was high at the previous edge.
- R8: If ref_gnt is sampled low while a refresh is in progress, then in the next cycle drive_en=0 and RAS# and CAS# are both high. No ref_done follows, the refresh stays owed, and ref_req returns one cycle later.
- R9: The row counter starts at 0 after reset and advances by one after each completed row-only refresh, wrapping from 2047 to 0. Column-strobe-first refreshes leave it unchanged.
- R10: Owed refreshes accumulate while no grant is given. After a grant, each completion removes exactly one, and all of them are issued back to back.
- R11: owe_err rises when the owed count reaches `OWE_MAX` and stays high until reset. The count saturates there, so at most `OWE_MAX` refreshes are owed at any time.
- R12: Changing cfg_ras_only after the grant does not alter the refresh already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ras_only | input | 1 | 1 = row-only refresh with block address; 0 = CAS#-first refresh |
| ref_gnt | input | 1 | Grant from the access controller; held for the whole refresh |
| ref_req | output | 1 | Refresh request, held until granted |
| ref_done | output | 1 | One-cycle pulse after a completed refresh |
| drive_en | output | 1 | Block owns the DRAM pins this cycle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low (held high) |
| dram_addr | output | ROW_W | Row address for row-only refresh, else 0 |
| owe_err | output | 1 | Sticky flag: owed count reached its ceiling |

## Verification
The bench withholds the grant across several intervals. A scheduler that kept only a single pending flag would then complete too few refreshes when the grant finally arrives. It also keeps the grant off long enough to pass the ceiling: a counter without saturation would issue extra catch-up refreshes, and an error flag that is not sticky would drop again. The bench pulls the grant mid-cycle to catch a design that finishes the refresh anyway or counts it as done. It flips the mode right after the grant to catch a design that decodes the live input. Finally, it runs more than 2048 row-only refreshes to expose a counter that fails to wrap, or one that also advances on column-strobe-first refreshes.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_LEAD,
    ST_RAS,
    ST_PRE,
    ST_DONE
  } ref_state_t;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 3000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_owe.sv
module refresh_owe #(
  parameter int OWE_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fin,
  output logic pending,
  output logic err
);
  localparam int OW_W = $clog2(OWE_MAX + 1);
  localparam logic [OW_W-1:0] CEIL = OW_W'(OWE_MAX);

  logic [OW_W-1:0] owe;

  always_ff @(posedge clk) begin
    if (rst) begin
      owe <= '0;
      err <= 1'b0;
    end else begin
      case ({tick, fin})
        2'b10: if (owe != CEIL) owe <= owe + 1'b1;
        2'b01: if (owe != '0) owe <= owe - 1'b1;
        default: owe <= owe;
      endcase
      if (tick && !fin && (owe >= CEIL - 1'b1)) err <= 1'b1;
    end
  end

  assign pending = (owe != '0);
endmodule

// File: rtl/refresh_rowctr.sv
module refresh_rowctr #(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst) row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int TRAS  = 10,
  parameter int TRP   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pending,
  input  logic             cfg_ras_only,
  input  logic             gnt,
  input  logic [ROW_W-1:0] row,
  output logic             fin,
  output logic             row_adv,
  output logic             req,
  output logic             done,
  output logic             drive_en,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  localparam int PH_MAX = (TRAS > TRP) ? TRAS : TRP;
  localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
  localparam logic [PH_W-1:0] RAS_LAST = PH_W'(TRAS - 1);
  localparam logic [PH_W-1:0] PRE_LAST = PH_W'(TRP - 1);

  ref_state_t      st, st_nxt;
  logic [PH_W-1:0] ph, ph_nxt;
  logic            mode_q, mode_nxt;
  logic            strobe_nxt;

  always_comb begin
    st_nxt = st;
    ph_nxt = ph;
    fin    = 1'b0;
    case (st)
      ST_IDLE: if (pending) st_nxt = ST_REQ;
      ST_REQ:  if (gnt) st_nxt = ST_LEAD;
      ST_LEAD: begin
        if (!gnt) st_nxt = ST_IDLE;
        else begin
          st_nxt = ST_RAS;
          ph_nxt = '0;
        end
      end
      ST_RAS: begin
        if (!gnt) st_nxt = ST_IDLE;
        else if (ph == RAS_LAST) begin
          st_nxt = ST_PRE;
          ph_nxt = '0;
        end else ph_nxt = ph + 1'b1;
      end
      ST_PRE: begin
        if (!gnt) st_nxt = ST_IDLE;
        else if (ph == PRE_LAST) begin
          st_nxt = ST_DONE;
          fin    = 1'b1;
        end else ph_nxt = ph + 1'b1;
      end
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign mode_nxt   = (st == ST_REQ && gnt) ? cfg_ras_only : mode_q;
  assign strobe_nxt = (st_nxt == ST_LEAD) || (st_nxt == ST_RAS);
  assign row_adv    = fin && mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= '0;
      mode_q   <= 1'b0;
      req      <= 1'b0;
      done     <= 1'b0;
      drive_en <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      addr     <= '0;
    end else begin
      st       <= st_nxt;
      ph       <= ph_nxt;
      mode_q   <= mode_nxt;
      req      <= (st_nxt == ST_REQ);
      done     <= (st_nxt == ST_DONE);
      drive_en <= strobe_nxt || (st_nxt == ST_PRE);
      ras_n    <= (st_nxt != ST_RAS);
      cas_n    <= !(strobe_nxt && !mode_nxt);
      we_n     <= 1'b1;
      addr     <= (strobe_nxt && mode_nxt) ? row : '0;
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int ROW_W    = 11,
  parameter int INTERVAL = 3000,
  parameter int OWE_MAX  = 8,
  parameter int TRAS     = 10,
  parameter int TRP      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_ras_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_done,
  output logic             drive_en,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic [ROW_W-1:0] dram_addr,
  output logic             owe_err
);
  logic             tick;
  logic             fin;
  logic             row_adv;
  logic             pending;
  logic [ROW_W-1:0] row;

  refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  refresh_owe #(.OWE_MAX(OWE_MAX)) u_owe (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .fin    (fin),
    .pending(pending),
    .err    (owe_err)
  );

  refresh_rowctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk),
    .rst(rst),
    .adv(row_adv),
    .row(row)
  );

  refresh_seq #(.ROW_W(ROW_W), .TRAS(TRAS), .TRP(TRP)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pending     (pending),
    .cfg_ras_only(cfg_ras_only),
    .gnt         (ref_gnt),
    .row         (row),
    .fin         (fin),
    .row_adv     (row_adv),
    .req         (ref_req),
    .done        (ref_done),
    .drive_en    (drive_en),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .addr        (dram_addr)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int TRAS = 10
) (
  input logic clk,
  input logic rst,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_done,
  input logic drive_en,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic owe_err
);
  logic [15:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst) lowcnt <= '0;
    else if (!dram_ras_n) lowcnt <= lowcnt + 1'b1;
    else lowcnt <= '0;
  end

  p_released_pins_r8: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (dram_ras_n && dram_cas_n && dram_we_n));

  p_cas_first_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));

  p_cas_stays_high_r4: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && dram_cas_n) |=> (dram_ras_n || dram_cas_n));

  p_ras_width_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(dram_ras_n) && drive_en) |-> (lowcnt == 16'(TRAS)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ref_done |=> !ref_done);

  p_we_high_r6: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> dram_we_n);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

  p_drive_granted_r7: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> $past(ref_gnt));

  p_req_not_driving_r7: assert property (@(posedge clk) disable iff (rst)
    !(ref_req && drive_en));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    owe_err |=> owe_err);
endmodule

bind refresh_sched refresh_sched_chk #(.TRAS(TRAS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_gnt   (ref_gnt),
  .ref_req   (ref_req),
  .ref_done  (ref_done),
  .drive_en  (drive_en),
  .dram_ras_n(dram_ras_n),
  .dram_cas_n(dram_cas_n),
  .dram_we_n (dram_we_n),
  .owe_err   (owe_err)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  localparam int ROW_W    = 11;
  localparam int INTERVAL = 40;
  localparam int OWE_MAX  = 4;
  localparam int TRAS     = 3;
  localparam int TRP      = 2;
  localparam int NROWS    = 1 << ROW_W;
  localparam int NVEC     = 6;
  // vector fields: [5] mode (1 = row-only), [4] flip mode after grant, [3:0] grant delay
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd0},
    {1'b1, 1'b0, 4'd0},
    {1'b1, 1'b1, 4'd3},
    {1'b0, 1'b0, 4'd5},
    {1'b1, 1'b0, 4'd1},
    {1'b0, 1'b1, 4'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg = 1'b0;
  logic             gnt = 1'b0;
  logic             ref_req, ref_done, drive_en;
  logic             dram_ras_n, dram_cas_n, dram_we_n, owe_err;
  logic [ROW_W-1:0] dram_addr;

  int edges = 0;
  int dones = 0;
  int tests = 0;
  int fails = 0;
  int exp_row = 0;

  always #2.5 clk = ~clk;

  refresh_sched #(
    .ROW_W(ROW_W), .INTERVAL(INTERVAL), .OWE_MAX(OWE_MAX), .TRAS(TRAS), .TRP(TRP)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_ras_only(cfg), .ref_gnt(gnt),
    .ref_req(ref_req), .ref_done(ref_done), .drive_en(drive_en),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .owe_err(owe_err)
  );

  always @(posedge clk) begin
    if (rst) begin
      edges <= 0;
      dones <= 0;
    end else begin
      edges <= edges + 1;
      if (ref_done) dones <= dones + 1;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    gnt = 1'b0;
    cfg = 1'b0;
    exp_row = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_edges(input int tgt);
    while (edges < tgt) @(negedge clk);
  endtask

  task automatic auto_run(input int tgt);
    while (edges < tgt) begin
      if (ref_req) gnt = 1'b1;
      else if (ref_done) gnt = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic do_refresh(input logic mode, input int dly, input logic flip);
    int   drv, rlow, pre, t;
    logic first_ok, cas_bad, we_bad, addr_bad;
    string tg;
    tg = mode ? "R4" : "R3";
    drv = 0; rlow = 0; pre = 0; t = 0;
    first_ok = 1'b0; cas_bad = 1'b0; we_bad = 1'b0; addr_bad = 1'b0;
    cfg = mode;
    while (!ref_req && t < 200) begin
      @(negedge clk);
      t++;
    end
    check_eq("R7 request raised", int'(ref_req), 1);
    for (int i = 0; i < dly; i++) begin
      check_eq("R7 request held without grant", int'(ref_req && !drive_en), 1);
      @(negedge clk);
    end
    check_eq("R7 pins not driven before grant", int'(drive_en), 0);
    gnt = 1'b1;
    t = 0;
    @(negedge clk);
    if (flip) cfg = ~mode;
    check_eq("R7 request dropped after grant", int'(ref_req), 0);
    check_eq("R7 driving after grant", int'(drive_en), 1);
    while (!ref_done && t < 60) begin
      if (drive_en) begin
        if (drv == 0) first_ok = mode ? (dram_ras_n && dram_cas_n) : (!dram_cas_n && dram_ras_n);
        drv++;
        if (!dram_ras_n) begin
          rlow++;
          if (int'(dram_addr) != (mode ? exp_row : 0)) addr_bad = 1'b1;
          if (!mode && dram_cas_n) cas_bad = 1'b1;
        end else if (rlow > 0 && dram_cas_n) pre++;
        if (mode && !dram_cas_n) cas_bad = 1'b1;
        if (!dram_we_n) we_bad = 1'b1;
      end
      @(negedge clk);
      t++;
    end
    check_eq(flip ? "R12 latched mode lead cycle" : {tg, " lead cycle"}, int'(first_ok), 1);
    check_eq({tg, " CAS# level during cycle"}, int'(cas_bad), 0);
    check_eq(mode ? "R9 row address" : "R3 address zero", int'(addr_bad), 0);
    check_eq("R6 WE# high", int'(we_bad), 0);
    check_eq("R5 driven cycles", drv, 1 + TRAS + TRP);
    check_eq("R5 RAS# low cycles", rlow, TRAS);
    check_eq("R5 precharge cycles", pre, TRP);
    check_eq("R5 done with pins released", int'(ref_done && !drive_en), 1);
    gnt = 1'b0;
    @(negedge clk);
    check_eq("R5 done is one cycle", int'(ref_done), 0);
    if (mode) exp_row = (exp_row + 1) % NROWS;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edges, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int tgt, n, bad, wrap_val;
    logic [ROW_W-1:0] cap;

    // R1 reset state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1 req/done/drive at reset", int'({ref_req, ref_done, drive_en}), 0);
    check_eq("R1 strobes high at reset", int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    check_eq("R1 addr and err at reset", int'(dram_addr) + int'(owe_err), 0);
    rst = 1'b0;

    // R2 first request timing
    wait_edges(INTERVAL + 1);
    check_eq("R2 no request before interval", int'(ref_req), 0);
    wait_edges(INTERVAL + 2);
    check_eq("R2 request after interval", int'(ref_req), 1);

    // table walk: R3 R4 R5 R6 R7 R9 R12
    for (int v = 0; v < NVEC; v++) begin
      do_refresh(VEC[v][5], int'(VEC[v][3:0]), VEC[v][4]);
    end
    do_refresh(1'b1, 0, 1'b0);
    check_eq("R9 counter after CBR mix", exp_row, 4);

    // R2 no refresh lost over time
    tgt = ((edges / INTERVAL) + 2) * INTERVAL - 5;
    auto_run(tgt);
    check_eq("R2 completions equal ticks", dones, tgt / INTERVAL);
    gnt = 1'b0;

    // R8 grant withdrawn mid-cycle
    do_reset();
    wait_edges(INTERVAL + 2);
    gnt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_eq("R8 RAS# low before withdrawal", int'(dram_ras_n), 0);
    gnt = 1'b0;
    @(negedge clk);
    check_eq("R8 pins released", int'({drive_en, dram_ras_n, dram_cas_n}), 3);
    @(negedge clk);
    check_eq("R8 request again, no done", int'({ref_req, dones == 0}), 3);
    do_refresh(1'b0, 0, 1'b0);
    check_eq("R8 refresh completed later", dones, 1);

    // R10 catch-up after delayed grant
    do_reset();
    wait_edges(3 * INTERVAL + 4);
    check_eq("R10 waiting with owed refreshes", int'({ref_req, drive_en, dones == 0}), 5);
    wait_edges(3 * INTERVAL + 5);
    auto_run(4 * INTERVAL - 5);
    check_eq("R10 three owed refreshes issued", dones, 3);
    auto_run(5 * INTERVAL - 5);
    check_eq("R10 steady after catch-up", dones, 4);
    check_eq("R11 no error below ceiling", int'(owe_err), 0);
    gnt = 1'b0;

    // R11 ceiling, error flag and saturation
    do_reset();
    wait_edges(4 * INTERVAL - 5);
    check_eq("R11 error clear below ceiling", int'(owe_err), 0);
    wait_edges(4 * INTERVAL + 5);
    check_eq("R11 error at ceiling", int'(owe_err), 1);
    wait_edges(6 * INTERVAL + 5);
    auto_run(8 * INTERVAL - 5);
    check_eq("R11 saturated owed count", dones, OWE_MAX + 1);
    check_eq("R11 error sticky", int'(owe_err), 1);
    gnt = 1'b0;
    do_reset();
    check_eq("R11 error cleared by reset", int'(owe_err), 0);

    // R9 row counter wrap over full row space
    cfg = 1'b1;
    n = 0;
    bad = 0;
    wrap_val = -1;
    cap = '0;
    while (n < NROWS + 2 && edges < 120000) begin
      if (ref_req) gnt = 1'b1;
      if (drive_en && !dram_ras_n) cap = dram_addr;
      if (ref_done) begin
        gnt = 1'b0;
        if (int'(cap) != n % NROWS) bad++;
        if (n == NROWS) wrap_val = int'(cap);
        n++;
      end
      @(negedge clk);
    end
    check_eq("R9 refresh count in wrap run", n, NROWS + 2);
    check_eq("R9 address sequence errors", bad, 0);
    check_eq("R9 wrap to row zero", wrap_val, 0);
    tgt = ((edges / INTERVAL) + 2) * INTERVAL - 5;
    auto_run(tgt);
    check_eq("R2 completions equal ticks in long run", dones, tgt / INTERVAL);
    gnt = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule